// File: doc/BRIEF.md
# Shared-Line Serial Result Sequencer

This block places one device's result word onto a serial data line that up to eight devices share, taking turns in a fixed order. Each device has a 3-bit position on the line. A 3-bit share setting gives the device count minus one, so a value of 3 means four devices. A data-ready pulse starts a round. In that round, the device at position 0 owns the first 32 serial clocks, position 1 owns the next 32, and so on up to the position equal to the share setting.

Inside its own slot a device raises its output enable and its frame output. It then shifts out the word it captured at the data-ready edge, most significant bit first, with the data changing on rising clock edges. It drops the line one clock before the slot ends, so the shared line always has one undriven clock between two devices. A device whose position is greater than the share setting is misconfigured: it never drives, and it reports the problem on a configuration error output. The output enable is meant to control a pad tristate cell, which sits outside this block.

Top module: `shared_line_seq`

## Requirements
- R1: On a rising edge with `data_ready` high, the block captures `result_word`, `dev_addr` and `share_cfg`. Changes to these inputs after that edge have no effect on the round in progress.
- R2: Count the rising edge that samples `data_ready` as edge 0. A device at position a first drives after edge 32*a+1, so position 0 starts after edge 1 and position 1 after edge 33.
- R3: In its slot, the bit on `sdo` at in-slot index i (0 to 30) is bit 31-i of the captured word, so the most significant bit comes first.
- R4: A device drives for 31 consecutive clocks and then leaves `sdo_oe` low for the 32nd clock of its slot. Bit 0 of the word is therefore never put on the line.
- R5: `frame_out` is high in exactly the cycles in which `sdo_oe` is high.
- R6: `sdo` is 0 in every cycle in which `sdo_oe` is low.
- R7: If `dev_addr` is greater than `share_cfg`, the device never raises `sdo_oe`. `cfg_err` shows the comparison of the live pins one clock later.
- R8: Once the slot of the position equal to the share setting has ended, the outputs stay low until the next `data_ready`.
- R9: During and after a synchronous reset (active-low `rst_n`), `sdo`, `sdo_oe`, `frame_out` and `cfg_err` are 0.
- R10: A `data_ready` during a round restarts it. The outputs are low after that edge, and the new round follows the timing of R2 counted from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| data_ready | input | 1 | One-cycle pulse that starts a round |
| dev_addr | input | 3 | Position of this device on the shared line |
| share_cfg | input | 3 | Number of devices on the line minus one |
| result_word | input | 32 | Result to send, captured at `data_ready` |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | High while this device drives the line |
| frame_out | output | 1 | Marks this device's driven slot |
| cfg_err | output | 1 | High when `dev_addr` is greater than `share_cfg` |

## Verification
Count the edge that samples `data_ready` as edge 0. After edge g, the expected `sdo_oe`, `frame_out` and `sdo` follow from simple arithmetic: the slot is (g-1)/32 and the in-slot index is (g-1) mod 32. `cfg_err` is due one edge after the pins change. The bench changes inputs on falling edges and compares outputs at the next falling edge, once per rising edge, starting with edge 1. It sweeps all 64 combinations of position and share setting. Each round also changes `result_word` right after the capture edge, and one run triggers a restart in mid-slot.

// File: rtl/shared_line_pkg.sv
// Package: shared definitions for the shared-line result sequencer.
// Assumes: the sub-modules and the top import these defaults and types.
package shared_line_pkg;
    localparam int unsigned DEF_DATA_W   = 32;
    localparam int unsigned DEF_SLOT_LEN = 32;
    localparam int unsigned DEF_GAP_LEN  = 1;
    localparam int unsigned DEF_ADDR_W   = 3;

    // Phase of the round timer.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } round_phase_e;
endpackage

// File: rtl/slot_round_timer.sv
// Module: slot_round_timer
// Keeps track of where a round stands: which slot and which index inside it.
// The start input has priority, restarts the round and sets the next index to slot 0, index 0.
// While running, slot/pos name the index that the next rising edge emits.
// Assumes: share_lim is stable while the round runs (it is latched elsewhere).
module slot_round_timer #(
    parameter int unsigned SLOT_LEN = shared_line_pkg::DEF_SLOT_LEN,
    parameter int unsigned ADDR_W   = shared_line_pkg::DEF_ADDR_W,
    localparam int unsigned POS_W   = $clog2(SLOT_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] share_lim,
    output logic              active,
    output logic [ADDR_W-1:0] slot,
    output logic [POS_W-1:0]  pos
);
    import shared_line_pkg::*;

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_LEN - 1);

    round_phase_e phase_q;

    // Moves the round position forward one index per clock and stops after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            slot    <= '0;
            pos     <= '0;
        end else if (start) begin
            phase_q <= PH_RUN;
            slot    <= '0;
            pos     <= '0;
        end else if (phase_q == PH_RUN) begin
            if (pos == LAST_POS) begin
                pos <= '0;
                if (slot == share_lim) begin
                    phase_q <= PH_IDLE;
                    slot    <= '0;
                end else begin
                    slot <= slot + 1'b1;
                end
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    assign active = (phase_q == PH_RUN);

    // R8: a running round never counts past the last configured slot.
    assert_slot_in_range_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        active |-> (slot <= share_lim)
    );
endmodule

// File: rtl/result_shifter.sv
// Module: result_shifter
// Holds the word captured at the start of a round and shifts it left, one bit per step.
// It presents the current most significant bit.
// Assumes: load and shift are never wanted in the same cycle (load wins).
module result_shifter #(
    parameter int unsigned DATA_W = shared_line_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] word_in,
    output logic              msb
);
    logic [DATA_W-1:0] sreg_q;

    // Captures the word on load and moves it one bit toward the top on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= word_in;
        end else if (shift) begin
            sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
        end
    end

    assign msb = sreg_q[DATA_W-1];
endmodule

// File: rtl/share_cfg_check.sv
// Module: share_cfg_check
// Latches the position and share setting at the start of a round and flags whether they are valid.
// Also produces a registered error flag from the live pins.
// Assumes: position and share setting are static in normal operation.
module share_cfg_check #(
    parameter int unsigned ADDR_W = shared_line_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] share_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] share_q,
    output logic              bad_q,
    output logic              err_live
);
    // Takes a snapshot of the configuration for the round that is starting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            share_q <= '0;
            bad_q   <= 1'b0;
        end else if (start) begin
            addr_q  <= addr_in;
            share_q <= share_in;
            bad_q   <= (addr_in > share_in);
        end
    end

    // Registers the validity of the live pins for the error output.
    always_ff @(posedge clk) begin
        if (!rst_n) err_live <= 1'b0;
        else        err_live <= (addr_in > share_in);
    end
endmodule

// File: rtl/shared_line_seq.sv
// Module: shared_line_seq (top)
// Puts this device's result word onto a shared serial line during its own slot.
// It drives 31 clocks of each 32-clock slot, so one idle clock separates neighbouring devices.
// Assumes: the pad tristate cell outside uses sdo_oe, and all devices see the same clk and data_ready.
module shared_line_seq #(
    parameter int unsigned DATA_W   = shared_line_pkg::DEF_DATA_W,
    parameter int unsigned SLOT_LEN = shared_line_pkg::DEF_SLOT_LEN,
    parameter int unsigned GAP_LEN  = shared_line_pkg::DEF_GAP_LEN,
    parameter int unsigned ADDR_W   = shared_line_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_ready,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [ADDR_W-1:0] share_cfg,
    input  logic [DATA_W-1:0] result_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              frame_out,
    output logic              cfg_err
);
    localparam int unsigned POS_W     = $clog2(SLOT_LEN);
    localparam int unsigned DRIVE_LEN = SLOT_LEN - GAP_LEN;

    logic              run_active;
    logic [ADDR_W-1:0] run_slot;
    logic [POS_W-1:0]  run_pos;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] share_q;
    logic              bad_q;
    logic              word_msb;
    logic              own_turn;

    share_cfg_check #(.ADDR_W(ADDR_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (data_ready),
        .addr_in  (dev_addr),
        .share_in (share_cfg),
        .addr_q   (addr_q),
        .share_q  (share_q),
        .bad_q    (bad_q),
        .err_live (cfg_err)
    );

    slot_round_timer #(.SLOT_LEN(SLOT_LEN), .ADDR_W(ADDR_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (data_ready),
        .share_lim (share_q),
        .active    (run_active),
        .slot      (run_slot),
        .pos       (run_pos)
    );

    // The next edge belongs to this device and lies in the driven part of its slot.
    always_comb begin
        own_turn = run_active && (run_slot == addr_q) && !bad_q
                   && (run_pos < POS_W'(DRIVE_LEN));
    end

    result_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (data_ready),
        .shift   (own_turn && !data_ready),
        .word_in (result_word),
        .msb     (word_msb)
    );

    // Registers the line outputs; a new data_ready silences them for one edge.
    always_ff @(posedge clk) begin
        if (!rst_n || data_ready) begin
            sdo       <= 1'b0;
            sdo_oe    <= 1'b0;
            frame_out <= 1'b0;
        end else begin
            sdo       <= own_turn & word_msb;
            sdo_oe    <= own_turn;
            frame_out <= own_turn;
        end
    end

    // R2: the drive begins only just after index 0 of a slot.
    assert_start_at_slot_head_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (run_pos == POS_W'(1))
    );

    // R4: the drive never covers the last index of a slot, leaving the gap.
    assert_gap_before_next_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (run_pos != '0)
    );

    // R5: the frame output tracks the output enable.
    assert_frame_matches_oe_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        frame_out == sdo_oe
    );

    // R6: no data level while the line is released.
    assert_quiet_when_off_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo
    );

    // R7: a misconfigured device never drives.
    assert_bad_cfg_silent_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        bad_q |-> !sdo_oe
    );

    // R8: an idle timer leads to a released line on the following edge.
    assert_idle_released_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !run_active |=> !sdo_oe
    );
endmodule

// File: tb/shared_line_seq_tb.sv
// Bench: runs every position and share setting and checks each edge against arithmetic expectations.
module shared_line_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int SLOT = 32;
    localparam int DRV  = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_ready = 1'b0;
    logic [2:0]  dev_addr = '0;
    logic [2:0]  share_cfg = '0;
    logic [31:0] result_word = '0;
    logic        sdo, sdo_oe, frame_out, cfg_err;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    shared_line_seq dut_i (
        .clk(clk), .rst_n(rst_n), .data_ready(data_ready),
        .dev_addr(dev_addr), .share_cfg(share_cfg), .result_word(result_word),
        .sdo(sdo), .sdo_oe(sdo_oe), .frame_out(frame_out), .cfg_err(cfg_err)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
        end
    endtask

    // Expected drive after edge g of a round (edge 0 samples data_ready).
    function automatic logic exp_drive(int g, int a, int s);
        int sl, p;
        if (g < 1 || a > s) return 1'b0;
        sl = (g - 1) / SLOT;
        p  = (g - 1) % SLOT;
        return (sl == a) && (sl <= s) && (p < DRV);
    endfunction

    function automatic logic exp_bit(int g, logic [31:0] w);
        int p;
        p = (g - 1) % SLOT;
        return w[31 - p];
    endfunction

    // Pulses data_ready on one edge, then scrambles result_word (R1: must be ignored).
    task automatic fire(input logic [31:0] w);
        @(negedge clk);
        data_ready = 1'b1;
        result_word = w;
        @(negedge clk);
        data_ready = 1'b0;
        result_word = ~w;
        check_bit("R10 outputs low after capture edge", sdo_oe, 1'b0);
    endtask

    // Compares edges 1..n of a round against the expectation.
    task automatic follow(input int n, input int a, input int s, input logic [31:0] w);
        for (int g = 1; g <= n; g++) begin
            logic e;
            @(negedge clk);
            e = exp_drive(g, a, s);
            check_bit("R2/R4/R7/R8 sdo_oe", sdo_oe, e);
            check_bit("R5 frame_out", frame_out, e);
            check_bit("R3/R6 sdo", sdo, e ? exp_bit(g, w) : 1'b0);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        dev_addr = 3'd7; share_cfg = 3'd0; data_ready = 1'b1;
        @(negedge clk);
        check_bit("R9 sdo_oe in reset", sdo_oe, 1'b0);
        check_bit("R9 frame in reset", frame_out, 1'b0);
        check_bit("R9 sdo in reset", sdo, 1'b0);
        check_bit("R9 cfg_err in reset", cfg_err, 1'b0);
        data_ready = 1'b0; dev_addr = '0;
        rst_n = 1'b1;

        // Sweep over every position and share setting (R1-R8).
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                logic [31:0] w;
                w = 32'hA5C3_0F96 ^ (32'(s * 8 + a) * 32'h9E37_79B9);
                @(negedge clk);
                dev_addr = 3'(a); share_cfg = 3'(s);
                @(negedge clk);
                check_bit("R7 cfg_err", cfg_err, (a > s) ? 1'b1 : 1'b0);
                fire(w);
                // R1: change configuration pins after capture; round must not change.
                dev_addr = 3'(7 - a); share_cfg = 3'(7 - s);
                follow(SLOT * (s + 1) + 3, a, s, w);
                dev_addr = 3'(a); share_cfg = 3'(s);
            end
        end

        // R10: restart in mid-slot, device at position 1 of two.
        @(negedge clk);
        dev_addr = 3'd1; share_cfg = 3'd1;
        fire(32'h1234_5678);
        follow(40, 1, 1, 32'h1234_5678);
        fire(32'hCAFE_F00D);
        follow(SLOT * 2 + 3, 1, 1, 32'hCAFE_F00D);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule